// File: doc/BRIEF.md
# Multi-channel fractional tick scheduler

This block divides a slow base tick strobe into several independent event channels. Each channel holds a rate selection taken from a small fixed table. On every base tick an enabled channel counts down, and it emits a one-cycle pulse when its count runs out. Some rates do not divide the base rate by a whole number. For those rates a second, small correction counter stretches every Nth period by one base tick, so that the average rate comes out exact over a short repeating group. For example, 60 Hz from a 500 Hz base produces three pulses for every 25 ticks.

Software or a neighbouring block selects a channel's rate through a configuration write port. That port never applies back-pressure: `cfg_ready` is held high, and a write completes on every cycle in which `cfg_valid` is high. A write that names a bad channel or a bad rate is dropped and answered with a one-cycle error flag. The lowest channels also keep a sticky interrupt request bit, which their own pulse sets and a per-bit clear input resets.

Top module: `frac_tick_sched`

## Requirements
- R1: A channel's counters change only on a cycle where `base_tick` is high or a configuration write targets that channel. Idle cycles between ticks neither advance the count nor produce a pulse.
- R2: The rate index maps as follows: 1 gives a pulse every base tick, 2 every 10 ticks, 4 every 5 ticks and 5 every 250 ticks. Index 3 is the fractional 60 Hz setting.
- R3: Index 0 switches a channel off. An off channel never pulses, however many ticks arrive.
- R4: `fire[c]` is high for exactly one cycle: the cycle after the clock edge at which the tick that ends the period is sampled.
- R5: At index 3 the periods after a configuration are 8, 8, 8, 9 ticks, and after that 8, 8, 9 repeating.
- R6: An accepted write reloads the channel at once and restarts its phase. The first pulse comes after one full period of the new rate, counted from the first tick after the write. `cfg_err` stays low.
- R7: After reset, channels 2 and 3 run at index 1 and every other channel is off. `fire`, `irq` and `cfg_err` are all low.
- R8: A write of index 0 to channel 2 or 3 is rejected. `cfg_err` pulses and the channel keeps running unchanged.
- R9: A write with an index above 5, or with a channel number of 6 or more, is rejected. `cfg_err` is high for one cycle and no channel's phase changes.
- R10: When a write and a tick reach the same channel in the same cycle, the write wins. That tick is not applied and the channel does not pulse. Other channels still see the tick.
- R11: Channels 0 to 3 each set `irq[c]` in the same cycle that `fire[c]` rises. The bit stays set until `irq_clr[c]` is seen, and a clear that coincides with a new pulse leaves the bit set.
- R12: `cfg_ready` is always high, so a write is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle base rate strobe |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Write accept, always high |
| cfg_chan | input | 3 | Target channel number |
| cfg_idx | input | 3 | Rate index, 0 to 5 |
| cfg_err | output | 1 | One-cycle reject flag, registered |
| fire | output | 6 | Per-channel one-cycle event pulse |
| irq | output | 4 | Sticky interrupt request, channels 0 to 3 |
| irq_clr | input | 4 | Per-bit interrupt clear |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a configuration write and a base tick. The bench lets a channel count to one tick short of its pulse, then issues the write with `base_tick` high. It judges the result by three things: no pulse on that channel, a full fresh period before the next pulse, and a pulse on a 500 Hz neighbour in that same cycle. The second pair is an interrupt clear and a new pulse. The bench asserts `irq_clr` on the exact tick that ends a period and requires the bit to read set afterwards.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int IDX_W     = 3;
  localparam int CNT_W     = 8;
  localparam int XTR_W     = 2;
  localparam int NUM_RATES = 6;

  typedef logic [IDX_W-1:0] rate_idx_t;

  typedef struct packed {
    logic [CNT_W-1:0] per;
    logic [XTR_W-1:0] xtr;
  } reload_t;

  function automatic reload_t rate_lookup(rate_idx_t i);
    reload_t r;
    case (i)
      3'd1:    begin r.per = CNT_W'(1);   r.xtr = XTR_W'(0); end
      3'd2:    begin r.per = CNT_W'(10);  r.xtr = XTR_W'(0); end
      3'd3:    begin r.per = CNT_W'(8);   r.xtr = XTR_W'(3); end
      3'd4:    begin r.per = CNT_W'(5);   r.xtr = XTR_W'(0); end
      3'd5:    begin r.per = CNT_W'(250); r.xtr = XTR_W'(0); end
      default: begin r.per = '0;          r.xtr = '0;        end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fts_rate_rom.sv
module fts_rate_rom
  import fts_pkg::*;
(
  input  rate_idx_t idx_i,
  output reload_t   rl_o
);
  always_comb rl_o = rate_lookup(idx_i);
endmodule

// File: rtl/fts_cfg_check.sv
module fts_cfg_check
  import fts_pkg::*;
#(
  parameter int                NUM_CH    = 6,
  parameter int                CH_W      = 3,
  parameter logic [NUM_CH-1:0] PROT_MASK = '0
) (
  input  logic              valid_i,
  input  logic [CH_W-1:0]   chan_i,
  input  rate_idx_t         idx_i,
  output logic [NUM_CH-1:0] load_o,
  output logic              bad_o
);
  logic chan_ok, idx_ok, prot_hit;

  always_comb begin
    chan_ok  = 1'b0;
    prot_hit = 1'b0;
    for (int j = 0; j < NUM_CH; j++) begin
      if (chan_i == CH_W'(j)) begin
        chan_ok  = 1'b1;
        prot_hit = PROT_MASK[j];
      end
    end
    idx_ok = (int'(idx_i) < NUM_RATES) && !(prot_hit && idx_i == '0);
    bad_o  = valid_i && !(chan_ok && idx_ok);
    for (int j = 0; j < NUM_CH; j++)
      load_o[j] = valid_i && chan_ok && idx_ok && (chan_i == CH_W'(j));
  end
endmodule

// File: rtl/fts_channel.sv
module fts_channel
  import fts_pkg::*;
#(
  parameter rate_idx_t RST_IDX = '0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      load_i,
  input  rate_idx_t load_idx_i,
  output logic      expire_o,
  output logic      fire_o
);
  rate_idx_t        idx_q, idx_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [XTR_W-1:0] xtr_q, xtr_n;
  logic             fire_q;
  reload_t          cur_rl, new_rl;
  logic             active;

  fts_rate_rom u_rom (.idx_i(idx_q), .rl_o(cur_rl));

  always_comb begin
    new_rl   = rate_lookup(load_idx_i);
    active   = (cnt_q != '0);
    expire_o = tick_i && active && !load_i && (cnt_q == CNT_W'(1));
    idx_n    = idx_q;
    cnt_n    = cnt_q;
    xtr_n    = xtr_q;
    if (load_i) begin
      idx_n = load_idx_i;
      cnt_n = new_rl.per;
      xtr_n = new_rl.xtr;
    end else if (tick_i && active) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_n = cur_rl.per;
        if (xtr_q != '0) begin
          if (xtr_q == XTR_W'(1)) begin
            cnt_n = cur_rl.per + CNT_W'(1);
            xtr_n = cur_rl.xtr;
          end else begin
            xtr_n = xtr_q - XTR_W'(1);
          end
        end
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= RST_IDX;
      cnt_q  <= rate_lookup(RST_IDX).per;
      xtr_q  <= rate_lookup(RST_IDX).xtr;
      fire_q <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
      xtr_q  <= xtr_n;
      fire_q <= expire_o;
    end
  end

  assign fire_o = fire_q;

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> !fire_q); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> ($stable(cnt_q) && $stable(xtr_q))); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !fire_q); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(251)); // R2
endmodule

// File: rtl/frac_tick_sched.sv
module frac_tick_sched
  import fts_pkg::*;
#(
  parameter int                NUM_CH    = 6,
  parameter int                NUM_IRQ   = 4,
  parameter logic [NUM_CH-1:0] PROT_MASK = 6'b001100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_tick,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [2:0]         cfg_chan,
  input  logic [IDX_W-1:0]   cfg_idx,
  output logic               cfg_err,
  output logic [NUM_CH-1:0]  fire,
  output logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_clr
);
  localparam int CH_W = 3;

  logic [NUM_CH-1:0]  load, expire;
  logic               bad, err_q;
  logic [NUM_IRQ-1:0] irq_q;

  assign cfg_ready = 1'b1;

  fts_cfg_check #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PROT_MASK(PROT_MASK)) u_chk (
    .valid_i(cfg_valid), .chan_i(cfg_chan), .idx_i(cfg_idx),
    .load_o(load), .bad_o(bad)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fts_channel #(.RST_IDX(PROT_MASK[g] ? rate_idx_t'(1) : rate_idx_t'(0))) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_i(base_tick), .load_i(load[g]),
      .load_idx_i(cfg_idx), .expire_o(expire[g]), .fire_o(fire[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad;
  end
  assign cfg_err = err_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= (irq_q[i] & ~irq_clr[i]) | expire[i];
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[i] && !irq_clr[i]) |=> irq_q[i]); // R11
    AST_FIRE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |-> irq_q[i]); // R11
  end
  assign irq = irq_q;

  AST_ERR_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(load) == '0); // R9
endmodule

// File: tb/frac_tick_sched_tb_top.sv
module frac_tick_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_ready;
  logic [2:0] cfg_chan = '0;
  logic [2:0] cfg_idx = '0;
  logic       cfg_err;
  logic [5:0] fire;
  logic [3:0] irq;
  logic [3:0] irq_clr = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  frac_tick_sched dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_chan(cfg_chan), .cfg_idx(cfg_idx),
    .cfg_err(cfg_err), .fire(fire), .irq(irq), .irq_clr(irq_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic do_cfg(input int ch, input int idx, input bit tk);
    cfg_valid = 1'b1; cfg_chan = 3'(ch); cfg_idx = 3'(idx); base_tick = tk;
    @(negedge clk);
    cfg_valid = 1'b0; base_tick = 1'b0;
  endtask

  task automatic step(input bit tk);
    base_tick = tk;
    @(negedge clk);
    base_tick = 1'b0;
  endtask

  // Counts ticks up to and including the one that produces a pulse on ch.
  task automatic to_fire(input int ch, input bit gap, output int n);
    n = 0;
    for (int k = 0; k < 600; k++) begin
      if (gap) begin
        step(1'b0);
        chk(fire[ch] == 1'b0, "R1 no pulse on idle cycle", int'(fire[ch]), 0);
      end
      step(1'b1);
      n++;
      if (fire[ch]) return;
    end
    n = -1;
  endtask

  function automatic int exp_period(input int idx, input int k);
    case (idx)
      1: return 1;
      2: return 10;
      3: return (k >= 3 && (k % 3) == 0) ? 9 : 8;
      4: return 5;
      default: return 250;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset state
    chk(fire == 6'b0, "R7 fire after reset", int'(fire), 0);
    chk(irq == 4'b0, "R7 irq after reset", int'(irq), 0);
    chk(cfg_err == 1'b0, "R7 err after reset", int'(cfg_err), 0);
    chk(cfg_ready == 1'b1, "R12 ready", int'(cfg_ready), 1);
    step(1'b1);
    chk(fire == 6'b001100, "R7 default rates", int'(fire), 12);
    step(1'b0);
    chk(fire == 6'b0, "R4 single-cycle pulse", int'(fire), 0);
    chk(irq == 4'b1100, "R11 irq set by default channels", int'(irq), 12);

    // Sweep every channel over every enabling rate
    for (int ch = 0; ch < 6; ch++) begin
      for (int idx = 1; idx < 6; idx++) begin
        do_cfg(ch, idx, 1'b0);
        chk(cfg_err == 1'b0, "R6 accepted write no error", int'(cfg_err), 0);
        chk(cfg_ready == 1'b1, "R12 ready during writes", int'(cfg_ready), 1);
        for (int k = 0; k < ((idx == 3) ? 7 : 4); k++) begin
          to_fire(ch, (k == 1), n);
          chk(n == exp_period(idx, k),
              (idx == 3) ? "R5 fractional period" : "R2 R6 period", n, exp_period(idx, k));
        end
        step(1'b0);
        chk(fire[ch] == 1'b0, "R4 pulse drops", int'(fire[ch]), 0);
      end
    end

    // R3 off channel stays silent
    do_cfg(0, 0, 1'b0);
    chk(cfg_err == 1'b0, "R3 off accepted on ch0", int'(cfg_err), 0);
    n = 0;
    for (int k = 0; k < 300; k++) begin
      step(1'b1);
      if (fire[0]) n++;
    end
    chk(n == 0, "R3 off channel pulses", n, 0);

    // R8 protected channel
    do_cfg(2, 0, 1'b0);
    chk(cfg_err == 1'b1, "R8 off on ch2 rejected", int'(cfg_err), 1);
    step(1'b0);
    chk(cfg_err == 1'b0, "R9 error one cycle", int'(cfg_err), 0);
    do_cfg(3, 0, 1'b0);
    chk(cfg_err == 1'b1, "R8 off on ch3 rejected", int'(cfg_err), 1);
    do_cfg(2, 1, 1'b0);
    step(1'b1);
    chk(fire[2] == 1'b1, "R8 ch2 still runs", int'(fire[2]), 1);

    // R9 bad index / channel mid-count on ch0 at 5 ticks
    do_cfg(0, 4, 1'b0);
    step(1'b1); step(1'b1);
    do_cfg(0, 7, 1'b0);
    chk(cfg_err == 1'b1, "R9 index 7 rejected", int'(cfg_err), 1);
    do_cfg(6, 2, 1'b0);
    chk(cfg_err == 1'b1, "R9 channel 6 rejected", int'(cfg_err), 1);
    do_cfg(7, 6, 1'b0);
    chk(cfg_err == 1'b1, "R9 channel 7 rejected", int'(cfg_err), 1);
    to_fire(0, 1'b0, n);
    chk(n == 3, "R9 phase unchanged", n, 3);

    // R10 write and tick collide on ch1 (10 ticks)
    do_cfg(1, 2, 1'b0);
    for (int k = 0; k < 9; k++) step(1'b1);
    do_cfg(1, 2, 1'b1);
    chk(fire[1] == 1'b0, "R10 tick dropped on written channel", int'(fire[1]), 0);
    chk(fire[2] == 1'b1, "R10 neighbour sees tick", int'(fire[2]), 1);
    to_fire(1, 1'b0, n);
    chk(n == 10, "R10 full fresh period", n, 10);

    // R11 irq sticky, clear, clear-vs-fire
    do_cfg(0, 4, 1'b0);
    irq_clr = 4'b1111; step(1'b0); irq_clr = '0;
    chk(irq[0] == 1'b0, "R11 cleared", int'(irq[0]), 0);
    to_fire(0, 1'b0, n);
    chk(irq[0] == 1'b1, "R11 set with pulse", int'(irq[0]), 1);
    for (int k = 0; k < 3; k++) step(1'b0);
    chk(irq[0] == 1'b1, "R11 sticky", int'(irq[0]), 1);
    irq_clr = 4'b0001; step(1'b0); irq_clr = '0;
    chk(irq[0] == 1'b0, "R11 clear", int'(irq[0]), 0);
    for (int k = 0; k < 4; k++) step(1'b1);
    irq_clr = 4'b0001; step(1'b1); irq_clr = '0;
    chk(fire[0] == 1'b1, "R11 pulse on clear cycle", int'(fire[0]), 1);
    chk(irq[0] == 1'b1, "R11 clear loses to pulse", int'(irq[0]), 1);

    summary();
  end
endmodule